// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block sits between a host and a four-channel, 16-bit successive-approximation converter that has a serial port. Each host configuration word starts one converter cycle. The block raises the conversion-start line and times the conversion period and the acquisition period in system clocks. It moves the configuration word out and a result word in over a serial clock that it generates itself.

The block offers three placements for the serial exchange inside the cycle:
- entirely inside the conversion period;
- entirely inside the acquisition period that follows;
- split into two bursts, the first inside the conversion period and the second after the conversion-start line falls.

A busy-flag option adds one leading serial clock to each exchange and shortens the conversion-start pulse to a single system cycle.

The converter returns each result two exchanges after the configuration word that set it up. The block tags every result with the channel field of that earlier word, so the host can match results to channels. The first two results after reset are undefined, and the block drops them.

Configuration words enter through a valid/ready stream. `cfg_ready` is high only while the sequencer is idle between cycles. A word is taken on a clock edge where `cfg_valid` and `cfg_ready` are both high. While `cfg_valid` is low, the sequencer stays idle with the conversion-start line low. Results leave as a single-cycle `res_valid` strobe without back-pressure, so the host must capture them when they appear. `mode` and `busy_en` are read only on the accepting edge.

Top module: `sar_seq`

## Requirements
- R1: An exchange has exactly 16 rising edges of `adc_sck`, or 17 when `busy_en` was high at acceptance. `adc_sck` is low whenever no exchange is in progress.
- R2: `adc_sdo` presents the configuration word most significant bit first, one bit per rising `adc_sck` edge. With the busy option, a 0 bit precedes bit 15.
- R3: `res_data` equals the last 16 `adc_sdi` bits sampled on rising `adc_sck` edges of the exchange, first sampled bit in the most significant position.
- R4: `res_chan` equals bits [10:9] of the configuration word accepted two exchanges before the exchange that produced `res_data`.
- R5: After reset, the first two completed exchanges produce no `res_valid`. Every later exchange produces exactly one single-cycle `res_valid`.
- R6: With the busy option off, `adc_cnv` is high for exactly CONV_CYC system cycles per cycle, provided the exchange placed in the conversion period fits within them. With the busy option on, it is high for one system cycle.
- R7: With `mode` = 0 (during conversion) and the busy option off, every serial clock pulse occurs while `adc_cnv` is high.
- R8: With `mode` = 1 or 3 (after conversion) and the busy option off, no serial clock pulse occurs while `adc_cnv` is high.
- R9: With `mode` = 2 (split) and the busy option off, 8 pulses occur while `adc_cnv` is high and 8 after it falls.
- R10: `cfg_ready` is low from the cycle after an acceptance until the cycle ends. While `cfg_valid` stays low in idle, no pulse on `adc_cnv` or `adc_sck` occurs.
- R11: A synchronous reset forces `adc_cnv`, `adc_sck` and `res_valid` low, returns to idle, and re-arms the two-result drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Exchange placement: 0 during, 1/3 after, 2 split |
| busy_en | input | 1 | Busy-flag option: extra leading clock, short start pulse |
| cfg_data | input | 16 | Configuration word; bits [10:9] are the channel |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_ready | output | 1 | Sequencer idle and able to take a word |
| res_data | output | 16 | Conversion result |
| res_chan | output | 2 | Channel tag of the result |
| res_valid | output | 1 | One-cycle result strobe |
| adc_cnv | output | 1 | Conversion-start line to the converter |
| adc_sck | output | 1 | Serial clock, idles low |
| adc_sdo | output | 1 | Serial data to the converter |
| adc_sdi | input | 1 | Serial data from the converter |

## Verification
Two events can fall into the same cycle.

The first pair is the final falling serial clock and the result strobe. In the after-conversion and split placements, the final falling serial clock comes near the end of acquisition, so the result strobe and the return to idle arrive almost together. The bench samples the strobe in every cycle until `cfg_ready` rises again and fails the check if it is missing or doubled.

The second pair is the acceptance edge and the start of the first serial burst. In the during-conversion and split placements, both land on the same edge. The shifted-out word captured at the converter side must still match the accepted word bit for bit.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {XM_DURING = 2'd0, XM_AFTER = 2'd1, XM_SPLIT = 2'd2, XM_AFTER2 = 2'd3} xfer_mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_ACQ} seq_state_e;
  localparam int WORD_W = 16;
  localparam int SHIFT_W = WORD_W + 1;
  localparam int CHAN_LSB = 9;
  localparam int CHAN_W = 2;
endpackage

// File: rtl/sar_sck_engine.sv
module sar_sck_engine #(
  parameter int SCK_DIV = 2,
  parameter int SW = 17,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          load,
  input  logic [SW-1:0] word,
  input  logic [CW-1:0] nbits,
  input  logic          sdi,
  output logic          active,
  output logic          done,
  output logic          sck,
  output logic          sdo,
  output logic [SW-1:0] rx
);
  localparam int DVW = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;

  logic [SW-1:0]  tx_q;
  logic [SW-1:0]  rx_q;
  logic [CW-1:0]  cnt_q;
  logic [DVW-1:0] div_q;
  logic           sck_q;
  logic           act_q;
  logic           div_end;

  assign div_end = (div_q == DVW'(SCK_DIV - 1));
  assign done    = act_q && div_end && sck_q && (cnt_q == CW'(1));
  assign active  = act_q;
  assign sck     = sck_q;
  assign sdo     = tx_q[SW-1];
  assign rx      = rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
      div_q <= '0;
      sck_q <= 1'b0;
      act_q <= 1'b0;
    end else if (start) begin
      act_q <= 1'b1;
      cnt_q <= nbits;
      div_q <= '0;
      sck_q <= 1'b0;
      if (load) tx_q <= word;
    end else if (act_q) begin
      if (div_end) begin
        div_q <= '0;
        sck_q <= !sck_q;
        if (!sck_q) begin
          rx_q <= {rx_q[SW-2:0], sdi};
        end else begin
          tx_q  <= {tx_q[SW-2:0], 1'b0};
          cnt_q <= cnt_q - CW'(1);
          if (cnt_q == CW'(1)) act_q <= 1'b0;
        end
      end else begin
        div_q <= div_q + DVW'(1);
      end
    end
  end

  // R1
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst) !act_q |-> !sck_q);
  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (rst) start |-> !act_q);
  // R1
  done_low_chk: assert property (@(posedge clk) disable iff (rst) done |=> (!sck_q && !act_q));
endmodule

// File: rtl/sar_frame_ctl.sv
module sar_frame_ctl
  import sar_seq_pkg::*;
#(
  parameter int CONV_CYC = 40,
  parameter int ACQ_CYC = 20,
  parameter int CW = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_valid,
  input  logic [1:0]         mode_in,
  input  logic               busy_in,
  input  logic [WORD_W-1:0]  cfg_in,
  input  logic               eng_active,
  input  logic               eng_done,
  output logic               cfg_ready,
  output logic               cnv,
  output logic               eng_start,
  output logic               eng_load,
  output logic [CW-1:0]      eng_nbits,
  output logic [SHIFT_W-1:0] eng_word,
  output logic               xfer_done,
  output logic [CHAN_W-1:0]  chan
);
  localparam int TMAX = (CONV_CYC > ACQ_CYC) ? CONV_CYC : ACQ_CYC;
  localparam int TW = $clog2(TMAX + 1);
  localparam int HALF = WORD_W / 2;

  seq_state_e        state_q;
  xfer_mode_e        mode_q;
  xfer_mode_e        mode_new;
  logic              busy_q;
  logic [WORD_W-1:0] cfg_q;
  logic [TW-1:0]     timer_q;
  logic              accept;
  logic              conv_end;
  logic              acq_end;

  function automatic logic is_after(input xfer_mode_e m);
    return (m == XM_AFTER) || (m == XM_AFTER2);
  endfunction

  function automatic logic [SHIFT_W-1:0] frame_word(input logic [WORD_W-1:0] w, input logic b);
    return b ? {1'b0, w} : {w, 1'b0};
  endfunction

  assign mode_new  = xfer_mode_e'(mode_in);
  assign cfg_ready = (state_q == ST_IDLE);
  assign accept    = cfg_ready && cfg_valid;
  assign conv_end  = (state_q == ST_CONV) && (timer_q >= TW'(CONV_CYC - 1)) && !eng_active;
  assign acq_end   = (state_q == ST_ACQ) && (timer_q >= TW'(ACQ_CYC - 1)) && !eng_active;
  assign cnv       = (state_q == ST_CONV) && (!busy_q || timer_q == '0);
  assign chan      = cfg_q[CHAN_LSB +: CHAN_W];
  assign xfer_done = eng_done && ((mode_q != XM_SPLIT) || (state_q == ST_ACQ));

  always_comb begin
    eng_start = 1'b0;
    eng_load  = 1'b0;
    eng_nbits = '0;
    eng_word  = frame_word(cfg_q, busy_q);
    if (accept) begin
      eng_word  = frame_word(cfg_in, busy_in);
      eng_start = !is_after(mode_new);
      eng_load  = 1'b1;
      eng_nbits = (mode_new == XM_SPLIT) ? CW'(HALF) + CW'(busy_in) : CW'(WORD_W) + CW'(busy_in);
    end else if (conv_end && mode_q != XM_DURING) begin
      eng_start = 1'b1;
      eng_load  = is_after(mode_q);
      eng_nbits = is_after(mode_q) ? CW'(WORD_W) + CW'(busy_q) : CW'(HALF);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= XM_DURING;
      busy_q  <= 1'b0;
      cfg_q   <= '0;
      timer_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_CONV;
          mode_q  <= mode_new;
          busy_q  <= busy_in;
          cfg_q   <= cfg_in;
          timer_q <= '0;
        end
        ST_CONV: if (conv_end) begin
          state_q <= ST_ACQ;
          timer_q <= '0;
        end else if (timer_q < TW'(TMAX)) begin
          timer_q <= timer_q + TW'(1);
        end
        ST_ACQ: if (acq_end) begin
          state_q <= ST_IDLE;
        end else if (timer_q < TW'(TMAX)) begin
          timer_q <= timer_q + TW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  after_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (is_after(mode_q) && cnv) |-> !eng_active);
  // R7
  during_place_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == XM_DURING && eng_active) |-> (state_q == ST_CONV));
  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst) accept |=> !cfg_ready);
  // R6
  busy_pulse_chk: assert property (@(posedge clk) disable iff (rst) (cnv && busy_q) |=> !cnv);
endmodule

// File: rtl/sar_tag_pipe.sv
module sar_tag_pipe #(
  parameter int DW = 16,
  parameter int CHW = 2,
  parameter int DROP = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           done,
  input  logic [CHW-1:0] chan_in,
  input  logic [DW-1:0]  data_in,
  output logic           res_valid,
  output logic [DW-1:0]  res_data,
  output logic [CHW-1:0] res_chan
);
  localparam int DRW = $clog2(DROP + 1);

  logic [CHW-1:0] tag0_q;
  logic [CHW-1:0] tag1_q;
  logic [DRW-1:0] drop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag0_q    <= '0;
      tag1_q    <= '0;
      drop_q    <= DRW'(DROP);
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
    end else if (done) begin
      tag0_q    <= chan_in;
      tag1_q    <= tag0_q;
      res_chan  <= tag1_q;
      res_data  <= data_in;
      res_valid <= (drop_q == '0);
      if (drop_q != '0) drop_q <= drop_q - DRW'(1);
    end else begin
      res_valid <= 1'b0;
    end
  end

  // R5
  drop_block_chk: assert property (@(posedge clk) disable iff (rst) (drop_q != '0) |=> !res_valid);
  // R5
  strobe_once_chk: assert property (@(posedge clk) disable iff (rst) res_valid |=> !res_valid);
  // R4
  tag_src_chk: assert property (@(posedge clk) disable iff (rst) res_valid |-> $past(done));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int CONV_CYC = 40,
  parameter int ACQ_CYC = 20,
  parameter int SCK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              busy_en,
  input  logic [WORD_W-1:0] cfg_data,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  output logic [WORD_W-1:0] res_data,
  output logic [CHAN_W-1:0] res_chan,
  output logic              res_valid,
  output logic              adc_cnv,
  output logic              adc_sck,
  output logic              adc_sdo,
  input  logic              adc_sdi
);
  localparam int CW = $clog2(SHIFT_W + 1);

  logic               eng_start;
  logic               eng_load;
  logic [CW-1:0]      eng_nbits;
  logic [SHIFT_W-1:0] eng_word;
  logic               eng_active;
  logic               eng_done;
  logic [SHIFT_W-1:0] eng_rx;
  logic               xfer_done;
  logic [CHAN_W-1:0]  cur_chan;

  sar_frame_ctl #(.CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC), .CW(CW)) u_ctl (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .mode_in(mode), .busy_in(busy_en),
    .cfg_in(cfg_data), .eng_active(eng_active), .eng_done(eng_done),
    .cfg_ready(cfg_ready), .cnv(adc_cnv), .eng_start(eng_start), .eng_load(eng_load),
    .eng_nbits(eng_nbits), .eng_word(eng_word), .xfer_done(xfer_done), .chan(cur_chan)
  );

  sar_sck_engine #(.SCK_DIV(SCK_DIV), .SW(SHIFT_W), .CW(CW)) u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .load(eng_load), .word(eng_word),
    .nbits(eng_nbits), .sdi(adc_sdi), .active(eng_active), .done(eng_done),
    .sck(adc_sck), .sdo(adc_sdo), .rx(eng_rx)
  );

  sar_tag_pipe #(.DW(WORD_W), .CHW(CHAN_W), .DROP(2)) u_tag (
    .clk(clk), .rst(rst), .done(xfer_done), .chan_in(cur_chan),
    .data_in(eng_rx[WORD_W-1:0]), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan)
  );
endmodule

// File: tb/sim_sar_seq.sv
module sim_sar_seq;
  localparam int CLK_PER = 10;
  localparam int CONV = 40;
  localparam int ACQ = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic busy_en = 1'b0;
  logic [15:0] cfg_data = '0;
  logic cfg_valid = 1'b0;
  logic cfg_ready;
  logic [15:0] res_data;
  logic [1:0] res_chan;
  logic res_valid;
  logic adc_cnv, adc_sck, adc_sdo;
  logic [16:0] adc_sreg = '0;
  logic adc_sdi;
  int total = 0;
  int bad = 0;
  int cyc = 0;
  int dropn = 2;
  logic [1:0] ch_m1 = '0, ch_m2 = '0;

  assign adc_sdi = adc_sreg[16];
  always #(CLK_PER / 2) clk = !clk;

  sar_seq #(.CONV_CYC(CONV), .ACQ_CYC(ACQ), .SCK_DIV(1)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .busy_en(busy_en), .cfg_data(cfg_data),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .res_data(res_data),
    .res_chan(res_chan), .res_valid(res_valid), .adc_cnv(adc_cnv), .adc_sck(adc_sck),
    .adc_sdo(adc_sdo), .adc_sdi(adc_sdi)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  task automatic check(input string req, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; cfg_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    dropn = 2; ch_m1 = '0; ch_m2 = '0;
  endtask

  // one converter cycle; checks R1..R10 for the frame
  task automatic frame(input logic [15:0] cfg, input logic [15:0] val, input logic [1:0] md, input logic bz);
    int rises = 0, rises_hi = 0, hi_cyc = 0, nval = 0, guard = 0;
    logic [16:0] cap = '0;
    logic [15:0] gdata = '0;
    logic [1:0] gchan = '0;
    logic psck = 1'b0, pcnv = 1'b0;
    logic exp_v = (dropn == 0);
    @(negedge clk);
    mode = md; busy_en = bz; cfg_data = cfg; cfg_valid = 1'b1;
    while (!cfg_ready) @(negedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
    check("R10 ready low after accept", !cfg_ready, cfg_ready, 0);
    while (!cfg_ready && guard < 500) begin
      guard++;
      if (adc_cnv && !pcnv) adc_sreg = bz ? {1'b1, val} : {val, 1'b0};
      if (adc_sck && !psck) begin
        rises++; cap = {cap[15:0], adc_sdo};
        if (adc_cnv) rises_hi++;
      end
      if (!adc_sck && psck) adc_sreg = {adc_sreg[15:0], 1'b0};
      if (adc_cnv) hi_cyc++;
      if (res_valid) begin nval++; gdata = res_data; gchan = res_chan; end
      psck = adc_sck; pcnv = adc_cnv;
      @(negedge clk);
    end
    if (res_valid) begin nval++; gdata = res_data; gchan = res_chan; end
    check("R1 sck pulse count", rises == 16 + int'(bz), rises, 16 + int'(bz));
    if (bz) check("R2 sdo bits busy", cap == {1'b0, cfg}, int'(cap), int'({1'b0, cfg}));
    else check("R2 sdo bits", cap[15:0] == cfg, int'(cap[15:0]), int'(cfg));
    check("R6 cnv high cycles", hi_cyc == (bz ? 1 : CONV), hi_cyc, bz ? 1 : CONV);
    if (!bz && md == 2'd0) check("R7 pulses in conversion", rises_hi == 16, rises_hi, 16);
    if (!bz && md[0]) check("R8 no pulse in conversion", rises_hi == 0, rises_hi, 0);
    if (!bz && md == 2'd2) check("R9 split first burst", rises_hi == 8, rises_hi, 8);
    check("R5 strobe count", nval == int'(exp_v), nval, int'(exp_v));
    if (exp_v && nval == 1) begin
      check("R3 result data", gdata == val, gdata, val);
      check("R4 channel tag", gchan == ch_m2, gchan, ch_m2);
    end
    ch_m2 = ch_m1; ch_m1 = cfg[10:9];
    if (dropn > 0) dropn--;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check("R11 cnv low in reset", !adc_cnv, adc_cnv, 0);
    check("R11 sck low in reset", !adc_sck, adc_sck, 0);
    check("R11 no strobe in reset", !res_valid, res_valid, 0);
    do_reset();
    check("R10 ready when idle", cfg_ready, cfg_ready, 1);
  endtask

  task automatic t_during();
    frame(16'h0200, 16'h1111, 2'd0, 1'b0);
    frame(16'h0400, 16'h2222, 2'd0, 1'b0);
    frame(16'h8600, 16'hA5C3, 2'd0, 1'b0);
    frame(16'h1234, 16'h0001, 2'd0, 1'b0);
  endtask

  task automatic t_after();
    frame(16'hFFFF, 16'h8000, 2'd1, 1'b0);
    frame(16'h0000, 16'h7FFF, 2'd3, 1'b0);
  endtask

  task automatic t_split();
    frame(16'h5A5A, 16'hC3A5, 2'd2, 1'b0);
    frame(16'h0600, 16'h0F0F, 2'd2, 1'b0);
  endtask

  task automatic t_busy();
    frame(16'h0200, 16'hBEEF, 2'd0, 1'b1);
    frame(16'h0400, 16'h1357, 2'd1, 1'b1);
    frame(16'h0600, 16'hFACE, 2'd2, 1'b1);
  endtask

  task automatic t_hold();
    int act = 0;
    repeat (20) begin
      @(negedge clk);
      if (adc_cnv || adc_sck || !cfg_ready) act++;
    end
    check("R10 idle without valid", act == 0, act, 0);
  endtask

  task automatic t_midreset();
    @(negedge clk);
    mode = 2'd0; busy_en = 1'b0; cfg_data = 16'h0200; cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R11 cnv forced low", !adc_cnv, adc_cnv, 0);
    check("R11 sck forced low", !adc_sck, adc_sck, 0);
    check("R11 strobe low", !res_valid, res_valid, 0);
    @(negedge clk);
    rst = 1'b0;
    dropn = 2; ch_m1 = '0; ch_m2 = '0;
    @(negedge clk);
    check("R11 idle after reset", cfg_ready, cfg_ready, 1);
    frame(16'h0600, 16'h4444, 2'd1, 1'b0);
    frame(16'h0200, 16'h5555, 2'd1, 1'b0);
    frame(16'h0400, 16'h6666, 2'd1, 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_during();
    t_hold();
    t_after();
    t_split();
    t_busy();
    t_midreset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule